// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block holds the hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) in which the integer and floating-point register files share one register index space. Each index is 6 bits wide, and its top bit picks the file: 1 selects the floating-point file and 0 selects the integer file. The block compares the source indices of the decode and execute stages with the destinations in flight. From this it produces operand-select codes, a load-use stall, and the redirect controls for branches and jumps resolved in execute.

All outputs are purely combinational. The execute stage picks each operand from the register file, from the memory-stage result or from the writeback result. The decode stage picks integer file data, float file data, or the value that writeback is writing in that same cycle. A load in execute that feeds the instruction in decode holds the front of the pipe for one cycle. A taken branch or a jump flushes the two younger instructions.

Top module: `hzc_top`

## Requirements
- R1: An execute source equal to the memory-stage destination, with the memory-stage write enable set, selects code 2'b01 (memory forward).
- R2: An execute source that matches only the writeback destination, with the writeback enable set, selects 2'b10; with no match it selects 2'b00 (register file).
- R3: When both the memory and the writeback destinations match an execute source, the memory forward (2'b01) wins.
- R4: A match requires all 6 index bits to be equal, so integer register n (top bit 0) and float register n (top bit 1) never match each other.
- R5: A destination of integer register 0 (index 6'b000000) never causes a forward, a decode bypass or a stall. Float register 0 (6'b100000) is forwarded like any other register.
- R6: The decode select is 2'b10 when writeback writes the same register in that cycle. Otherwise it is 2'b01 when the source's top bit is 1 and 2'b00 when it is 0.
- R7: A destination whose write enable is clear never causes a forward or a bypass.
- R8: When execute holds a load (write enable and load flag set) whose destination matches either decode source, the stall output and the execute bubble are 1 and the next-PC select stays 0.
- R9: A taken branch or a jump in execute sets the next-PC select to 1 (target) and sets the fetch/decode flush and the execute bubble. It clears the stall even when a load-use hazard is present in the same cycle.
- R10: With no taken branch, no jump and no load-use hazard, the stall, both flushes and the next-PC select are all 0.
- R11: A matching execute producer that is not a load causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 6 | Decode-stage first source index |
| id_rs2 | input | 6 | Decode-stage second source index |
| ex_rs1 | input | 6 | Execute-stage first source index |
| ex_rs2 | input | 6 | Execute-stage second source index |
| ex_rd | input | 6 | Execute-stage destination index |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 6 | Memory-stage destination index |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 6 | Writeback destination index |
| wb_wr_en | input | 1 | Writeback write enable |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| ex_is_jump | input | 1 | Execute holds an unconditional jump |
| id_rs1_sel | output | 2 | Decode operand 1 select: 00 int, 01 float, 10 writeback bypass |
| id_rs2_sel | output | 2 | Decode operand 2 select, same coding |
| ex_rs1_sel | output | 2 | Execute operand 1 select: 00 file, 01 memory, 10 writeback |
| ex_rs2_sel | output | 2 | Execute operand 2 select, same coding |
| pc_sel | output | 1 | Next-PC select: 0 sequential, 1 computed target |
| stall_front | output | 1 | Hold PC and the fetch/decode register |
| flush_ifid | output | 1 | Clear the fetch/decode register |
| bubble_idex | output | 1 | Load a bubble into the decode/execute register |

## Verification
The bench builds the block with its default 6-bit index width, since the file-select bit and the special handling of integer register 0 only mean something at that width. Random indices are drawn from a small pool that mixes integer 0, float 0 and integer/float pairs with equal low bits. This makes simultaneous memory and writeback matches, cross-file near-misses and load-use hazards that coincide with redirects occur often. Directed cases pin down each of these corners on its own.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    EXS_FILE = 2'b00,
    EXS_MEM  = 2'b01,
    EXS_WB   = 2'b10
  } ex_sel_e;

  typedef enum logic [1:0] {
    IDS_INT = 2'b00,
    IDS_FLT = 2'b01,
    IDS_WB  = 2'b10
  } id_sel_e;
endpackage

// File: rtl/hzc_dep_cmp.sv
module hzc_dep_cmp #(
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] dst,
  input  logic             dst_we,
  output logic             hit
);
  // integer register 0 is hardwired; every other index (float 0 included) counts
  function automatic logic dep_match(logic [IDX_W-1:0] s, logic [IDX_W-1:0] d, logic we);
    return we && (s == d) && (d != '0);
  endfunction

  assign hit = dep_match(src, dst, dst_we);
endmodule

// File: rtl/hzc_ex_fwd.sv
module hzc_ex_fwd
  import hzc_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       sel
);
  logic mem_hit, wb_hit;
  ex_sel_e pick;

  hzc_dep_cmp #(.IDX_W(IDX_W)) u_mem_cmp (.src(src), .dst(mem_rd), .dst_we(mem_we), .hit(mem_hit));
  hzc_dep_cmp #(.IDX_W(IDX_W)) u_wb_cmp  (.src(src), .dst(wb_rd),  .dst_we(wb_we),  .hit(wb_hit));

  // the younger producer (memory stage) takes priority
  always_comb begin
    if (mem_hit)     pick = EXS_MEM;
    else if (wb_hit) pick = EXS_WB;
    else             pick = EXS_FILE;
  end

  assign sel = pick;
endmodule

// File: rtl/hzc_id_sel.sv
module hzc_id_sel
  import hzc_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       sel
);
  localparam int unsigned FILE_BIT = IDX_W - 1;
  logic wb_hit;
  id_sel_e pick;

  hzc_dep_cmp #(.IDX_W(IDX_W)) u_wb_cmp (.src(src), .dst(wb_rd), .dst_we(wb_we), .hit(wb_hit));

  always_comb begin
    if (wb_hit)             pick = IDS_WB;
    else if (src[FILE_BIT]) pick = IDS_FLT;
    else                    pick = IDS_INT;
  end

  assign sel = pick;
endmodule

// File: rtl/hzc_flow.sv
module hzc_flow #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] lu_hit,
  input  logic               br_taken,
  input  logic               is_jump,
  output logic               redirect,
  output logic               load_use,
  output logic               pc_sel,
  output logic               stall_front,
  output logic               flush_ifid,
  output logic               bubble_idex
);
  assign redirect    = br_taken | is_jump;
  assign load_use    = |lu_hit;
  assign pc_sel      = redirect;
  // a redirect discards the stalled instruction, so the hold is dropped
  assign stall_front = load_use & ~redirect;
  assign flush_ifid  = redirect;
  assign bubble_idex = redirect | load_use;
endmodule

// File: rtl/hzc_top.sv
module hzc_top #(
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic [IDX_W-1:0] ex_rs1,
  input  logic [IDX_W-1:0] ex_rs2,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_wr_en,
  input  logic             ex_is_load,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_wr_en,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_wr_en,
  input  logic             ex_br_taken,
  input  logic             ex_is_jump,
  output logic [1:0]       id_rs1_sel,
  output logic [1:0]       id_rs2_sel,
  output logic [1:0]       ex_rs1_sel,
  output logic [1:0]       ex_rs2_sel,
  output logic             pc_sel,
  output logic             stall_front,
  output logic             flush_ifid,
  output logic             bubble_idex
);
  localparam int unsigned NUM_SRC = 2;

  logic [IDX_W-1:0] id_src [NUM_SRC];
  logic [IDX_W-1:0] ex_src [NUM_SRC];
  logic [1:0]       id_sel [NUM_SRC];
  logic [1:0]       ex_sel [NUM_SRC];
  logic [NUM_SRC-1:0] lu_hit;
  logic             ld_producer;
  logic             redirect_w;
  logic             load_use_w;

  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;
  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;
  assign ld_producer = ex_wr_en & ex_is_load;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzc_ex_fwd #(.IDX_W(IDX_W)) u_ex_fwd (
      .src(ex_src[g]), .mem_rd(mem_rd), .mem_we(mem_wr_en),
      .wb_rd(wb_rd), .wb_we(wb_wr_en), .sel(ex_sel[g])
    );
    hzc_id_sel #(.IDX_W(IDX_W)) u_id_sel (
      .src(id_src[g]), .wb_rd(wb_rd), .wb_we(wb_wr_en), .sel(id_sel[g])
    );
    hzc_dep_cmp #(.IDX_W(IDX_W)) u_lu_cmp (
      .src(id_src[g]), .dst(ex_rd), .dst_we(ld_producer), .hit(lu_hit[g])
    );
  end

  hzc_flow #(.NUM_SRC(NUM_SRC)) u_flow (
    .lu_hit(lu_hit), .br_taken(ex_br_taken), .is_jump(ex_is_jump),
    .redirect(redirect_w), .load_use(load_use_w), .pc_sel(pc_sel),
    .stall_front(stall_front), .flush_ifid(flush_ifid), .bubble_idex(bubble_idex)
  );

  assign id_rs1_sel = id_sel[0];
  assign id_rs2_sel = id_sel[1];
  assign ex_rs1_sel = ex_sel[0];
  assign ex_rs2_sel = ex_sel[1];
endmodule

// File: rtl/hzc_checker.sv
module hzc_checker #(
  parameter int unsigned IDX_W = 6
) (
  input logic [IDX_W-1:0] ex_rs1,
  input logic [IDX_W-1:0] mem_rd,
  input logic             mem_wr_en,
  input logic [IDX_W-1:0] wb_rd,
  input logic             wb_wr_en,
  input logic [1:0]       id_rs1_sel,
  input logic [1:0]       id_rs2_sel,
  input logic [1:0]       ex_rs1_sel,
  input logic             redirect_w,
  input logic             load_use_w,
  input logic             pc_sel,
  input logic             stall_front,
  input logic             flush_ifid,
  input logic             bubble_idex
);
  always_comb begin
    // R3
    mem_prio_chk: assert (!(mem_wr_en && mem_rd == ex_rs1 && mem_rd != '0) || ex_rs1_sel == 2'b01);
    // R5
    zero_dst_chk: assert (!(mem_rd == '0 && wb_rd == '0) || ex_rs1_sel == 2'b00);
    // R7
    wb_off_chk: assert (wb_wr_en || (id_rs1_sel != 2'b10 && id_rs2_sel != 2'b10));
    // R6
    id_code_chk: assert (id_rs1_sel != 2'b11 && id_rs2_sel != 2'b11);
    // R9
    redirect_chk: assert (!redirect_w || (pc_sel && flush_ifid && bubble_idex && !stall_front));
    // R8
    load_use_chk: assert (!(load_use_w && !redirect_w) || (stall_front && bubble_idex && !pc_sel));
    // R10
    quiet_chk: assert (redirect_w || load_use_w || (!stall_front && !flush_ifid && !bubble_idex && !pc_sel));
  end
endmodule

bind hzc_top hzc_checker #(.IDX_W(IDX_W)) i_hzc_checker (
  .ex_rs1(ex_rs1), .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
  .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
  .id_rs1_sel(id_rs1_sel), .id_rs2_sel(id_rs2_sel), .ex_rs1_sel(ex_rs1_sel),
  .redirect_w(redirect_w), .load_use_w(load_use_w), .pc_sel(pc_sel),
  .stall_front(stall_front), .flush_ifid(flush_ifid), .bubble_idex(bubble_idex)
);

// File: tb/test_hzc_top.sv
`timescale 1ns/1ps
module test_hzc_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [5:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_wr_en, ex_is_load, mem_wr_en, wb_wr_en, ex_br_taken, ex_is_jump;
  logic [1:0] id_rs1_sel, id_rs2_sel, ex_rs1_sel, ex_rs2_sel;
  logic pc_sel, stall_front, flush_ifid, bubble_idex;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  hzc_top i_hzc_top (.*);

  function automatic logic [1:0] want_ex(logic [5:0] s, logic [5:0] mr, logic mw, logic [5:0] wr, logic ww);
    logic [1:0] r = 2'b00;
    if (ww && wr != 6'd0 && wr == s) r = 2'b10;
    if (mw && mr != 6'd0 && mr == s) r = 2'b01;
    return r;
  endfunction

  function automatic logic [1:0] want_id(logic [5:0] s, logic [5:0] wr, logic ww);
    if (ww && wr == s && wr != 6'd0) return 2'b10;
    return {1'b0, s[5]};
  endfunction

  function automatic logic want_lu();
    return ex_wr_en && ex_is_load && ex_rd != 6'd0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {ex_wr_en, ex_is_load, mem_wr_en, wb_wr_en, ex_br_taken, ex_is_jump} = '0;
  endtask

  task automatic settle();
    #2;
    @(negedge clk);
    #1;
  endtask

  task automatic check_all(string tag);
    logic redir, lu;
    redir = ex_br_taken | ex_is_jump;
    lu = want_lu();
    chk({tag, " R1 ex_rs1_sel"}, ex_rs1_sel, want_ex(ex_rs1, mem_rd, mem_wr_en, wb_rd, wb_wr_en));
    chk({tag, " R2 ex_rs2_sel"}, ex_rs2_sel, want_ex(ex_rs2, mem_rd, mem_wr_en, wb_rd, wb_wr_en));
    chk({tag, " R6 id_rs1_sel"}, id_rs1_sel, want_id(id_rs1, wb_rd, wb_wr_en));
    chk({tag, " R6 id_rs2_sel"}, id_rs2_sel, want_id(id_rs2, wb_rd, wb_wr_en));
    chk({tag, " R9 pc_sel"}, pc_sel, redir);
    chk({tag, " R9 flush_ifid"}, flush_ifid, redir);
    chk({tag, " R8 stall_front"}, stall_front, lu && !redir);
    chk({tag, " R8 bubble_idex"}, bubble_idex, lu || redir);
  endtask

  function automatic logic [5:0] pool();
    case ($urandom % 8)
      0: return 6'd0;
      1: return 6'd32;
      2: return 6'd3;
      3: return 6'd35;
      4: return 6'd7;
      5: return 6'd39;
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    #(10 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    settle();
    // R10 quiet state
    chk("R10 stall", stall_front, 0);
    chk("R10 flush", flush_ifid, 0);
    chk("R10 pc_sel", pc_sel, 0);
    chk("R10 bubble", bubble_idex, 0);

    // R1 memory forward
    idle(); ex_rs1 = 6'd9; mem_rd = 6'd9; mem_wr_en = 1; settle();
    chk("R1 mem fwd", ex_rs1_sel, 2'b01);
    // R2 writeback forward and no match
    idle(); ex_rs2 = 6'd12; wb_rd = 6'd12; wb_wr_en = 1; ex_rs1 = 6'd13; settle();
    chk("R2 wb fwd", ex_rs2_sel, 2'b10);
    chk("R2 no match", ex_rs1_sel, 2'b00);
    // R3 priority
    idle(); ex_rs1 = 6'd40; mem_rd = 6'd40; wb_rd = 6'd40; mem_wr_en = 1; wb_wr_en = 1; settle();
    chk("R3 mem over wb", ex_rs1_sel, 2'b01);
    // R4 cross-file no match
    idle(); ex_rs1 = 6'd5; mem_rd = 6'd37; mem_wr_en = 1; id_rs1 = 6'd37; ex_rd = 6'd5;
    ex_wr_en = 1; ex_is_load = 1; wb_rd = 6'd5; wb_wr_en = 1; settle();
    chk("R4 cross-file ex", ex_rs1_sel, 2'b10);
    chk("R4 cross-file stall", stall_front, 0);
    // R5 x0 vs f0
    idle(); ex_rs1 = 6'd0; mem_rd = 6'd0; mem_wr_en = 1; ex_rs2 = 6'd32; wb_rd = 6'd32; wb_wr_en = 1; settle();
    chk("R5 x0 no fwd", ex_rs1_sel, 2'b00);
    chk("R5 f0 fwd", ex_rs2_sel, 2'b10);
    idle(); id_rs1 = 6'd0; ex_rd = 6'd0; ex_wr_en = 1; ex_is_load = 1; wb_rd = 6'd0; wb_wr_en = 1; settle();
    chk("R5 x0 no stall", stall_front, 0);
    chk("R5 x0 no bypass", id_rs1_sel, 2'b00);
    // R6 decode selects
    idle(); id_rs1 = 6'd33; id_rs2 = 6'd4; settle();
    chk("R6 float file", id_rs1_sel, 2'b01);
    chk("R6 int file", id_rs2_sel, 2'b00);
    wb_rd = 6'd33; wb_wr_en = 1; settle();
    chk("R6 wb bypass", id_rs1_sel, 2'b10);
    // R7 disabled enables
    idle(); ex_rs1 = 6'd8; mem_rd = 6'd8; wb_rd = 6'd8; id_rs1 = 6'd8; settle();
    chk("R7 no fwd", ex_rs1_sel, 2'b00);
    chk("R7 no bypass", id_rs1_sel, 2'b00);
    // R8 load-use on second source
    idle(); id_rs2 = 6'd34; ex_rd = 6'd34; ex_wr_en = 1; ex_is_load = 1; settle();
    chk("R8 stall", stall_front, 1);
    chk("R8 bubble", bubble_idex, 1);
    chk("R8 pc_sel", pc_sel, 0);
    // R9 jump overrides load-use
    ex_is_jump = 1; settle();
    chk("R9 stall cleared", stall_front, 0);
    chk("R9 flush", flush_ifid, 1);
    chk("R9 pc_sel", pc_sel, 1);
    // R11 non-load producer
    idle(); id_rs1 = 6'd11; ex_rd = 6'd11; ex_wr_en = 1; settle();
    chk("R11 no stall", stall_front, 0);
    chk("R11 no bubble", bubble_idex, 0);

    for (int i = 0; i < 3000; i++) begin
      id_rs1 = pool(); id_rs2 = pool(); ex_rs1 = pool(); ex_rs2 = pool();
      ex_rd = pool(); mem_rd = pool(); wb_rd = pool();
      ex_wr_en = 1'($urandom); ex_is_load = 1'($urandom); mem_wr_en = 1'($urandom);
      wb_wr_en = 1'($urandom);
      ex_br_taken = ($urandom % 5) == 0; ex_is_jump = ($urandom % 7) == 0;
      settle();
      check_all("rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule